// File: doc/BRIEF.md
# Per-Task Address Relocation and Bounds Unit

This unit sits between a processor and its memory system. Every task sees its own address space starting at virtual address zero. The unit adds a per-task base to the virtual address of each request, so the same virtual address reaches a different physical location for each task. The active task is given by a task-select input.

Before it converts a request, the unit checks that the whole access lies inside the task's space. An access that reaches past the end of that space, even by one byte, is not converted. The unit raises a one-cycle fault pulse instead and keeps the offending virtual address in a sticky status register. A privileged agent loads the base and size of each task through a write port. Writes made without privilege are dropped, so an unprivileged task cannot enlarge its own space.

The result stage is a three-state machine:

- **IDLE**: nothing is presented.
- **PASS**: a translated address is presented for one cycle.
- **TRAP**: the fault pulse is raised for one cycle.

The state is chosen on every clock from the incoming request:

- no request goes to IDLE;
- a request inside the task's space goes to PASS;
- any other request goes to TRAP.

Any state can move to any other state on the next clock.

Top module: `task_reloc_unit`

## Requirements
- R1: After reset, `rsp_valid` and `fault_pulse` are low and `fault_addr` is zero. All base and size registers are zero, so every request faults until they are programmed.
- R2: A request that passes produces `rsp_valid` high on the cycle after it was sampled. `rsp_addr` is then (virtual address + base) modulo 2^32, and `rsp_write` and `rsp_size` repeat the request's flags.
- R3: The base and size used for a request are those of the task given on `cur_task` in the cycle the request is sampled.
- R4: The size code is 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. Code 3 is reserved and always faults.
- R5: The task's size register holds the byte count of its space. An access passes only if virtual address + byte count ≤ size, computed without wraparound. Otherwise it faults.
- R6: A faulting request gives no `rsp_valid`. It gives `fault_pulse` high for exactly the following cycle, and `fault_addr` takes its virtual address. `fault_addr` keeps that value until the next fault.
- R7: A configuration write takes effect only while `cfg_priv` is high. `cfg_field` 0 selects the base and 1 selects the size, and `cfg_task` selects the task. A write with `cfg_priv` low changes nothing.
- R8: When a configuration write and a request fall in the same cycle, the request uses the old value. The new value applies from the next cycle.
- R9: A cycle with no request gives neither `rsp_valid` nor `fault_pulse` on the next cycle. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Writer is privileged; a write is dropped without it |
| cfg_field | input | 1 | 0 = base register, 1 = size register |
| cfg_task | input | 3 | Task whose register is written |
| cfg_data | input | 32 | Value to write |
| cur_task | input | 3 | Task currently running |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Transfer size code |
| rsp_valid | output | 1 | Translated request present |
| rsp_addr | output | 32 | Physical address |
| rsp_write | output | 1 | Repeated write flag |
| rsp_size | output | 2 | Repeated size code |
| fault_pulse | output | 1 | One-cycle bounds fault |
| fault_addr | output | 32 | Virtual address of the last fault (sticky) |

## Verification
The assertions check on every cycle that:

- a pass and a fault never show together, and each appears only after a request;
- a passing result repeats the request's flags;
- the sticky fault address moves only on a fault, and then to the faulting virtual address;
- the reserved size code always traps.

Only the bench's scenarios can show:

- the address arithmetic, including wraparound;
- the exact last-byte edges of the size check for each transfer width;
- the separation between tasks;
- that unprivileged writes are dropped;
- that a write in the same cycle as a request does not reach that request.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

    parameter int unsigned ADDR_W    = 32;
    parameter int unsigned NUM_TASKS = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_TRAP = 2'd2
    } out_state_e;

    typedef enum logic {
        CFG_BASE  = 1'b0,
        CFG_LIMIT = 1'b1
    } cfg_field_e;

endpackage

// File: rtl/reloc_regfile.sv
module reloc_regfile #(
    parameter int unsigned AW = 32,
    parameter int unsigned NT = 8,
    localparam int unsigned TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_priv,
    input  logic          wr_field,
    input  logic [TW-1:0] wr_task,
    input  logic [AW-1:0] wr_data,
    input  logic [TW-1:0] rd_task,
    output logic [AW-1:0] rd_base,
    output logic [AW-1:0] rd_limit
);
    import reloc_pkg::*;

    logic [AW-1:0] base_q  [NT];
    logic [AW-1:0] limit_q [NT];

    // Only a privileged write may land; an unprivileged strobe is dropped.
    logic wr_ok;
    assign wr_ok = wr_en && wr_priv;

    for (genvar t = 0; t < NT; t++) begin : g_task
        logic hit;
        assign hit = wr_ok && (wr_task == TW'(t));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[t]  <= '0;
                limit_q[t] <= '0;
            end else if (hit) begin
                if (cfg_field_e'(wr_field) == CFG_LIMIT) begin
                    limit_q[t] <= wr_data;
                end else begin
                    base_q[t]  <= wr_data;
                end
            end
        end
    end

    always_comb begin
        rd_base  = '0;
        rd_limit = '0;
        for (int t = 0; t < NT; t++) begin
            if (rd_task == TW'(t)) begin
                rd_base  = base_q[t];
                rd_limit = limit_q[t];
            end
        end
    end

endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] va,
    input  logic [1:0]    size,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic [AW-1:0] pa,
    output logic          in_bounds
);
    import reloc_pkg::*;

    localparam int unsigned EW = AW + 1;

    logic [2:0]    nbytes;
    logic          size_ok;
    logic [EW-1:0] end_excl;

    always_comb begin
        size_ok = 1'b1;
        unique case (xfer_size_e'(size))
            SZ_BYTE: nbytes = 3'd1;
            SZ_HALF: nbytes = 3'd2;
            SZ_WORD: nbytes = 3'd4;
            default: begin
                nbytes  = 3'd0;
                size_ok = 1'b0;
            end
        endcase
    end

    // One bit wider than the address, so an access running past the top of
    // the address space cannot wrap back under the size.
    assign end_excl  = {1'b0, va} + EW'(nbytes);
    assign in_bounds = size_ok && (end_excl <= {1'b0, limit});
    assign pa        = va + base;

endmodule

// File: rtl/reloc_fsm.sv
module reloc_fsm #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_ok,
    input  logic [AW-1:0] req_va,
    input  logic [AW-1:0] req_pa,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_write,
    output logic [1:0]    rsp_size,
    output logic          fault_pulse,
    output logic [AW-1:0] fault_addr
);
    import reloc_pkg::*;

    out_state_e    state_q, state_d;
    logic [AW-1:0] addr_q, fva_q;
    logic          wr_q;
    logic [1:0]    sz_q;

    // Transition choice: IDLE without a request, PASS when in bounds,
    // TRAP otherwise, reachable from every state.
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            state_d = req_ok ? ST_PASS : ST_TRAP;
        end
    end

    // State register plus payload and sticky fault capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            sz_q    <= 2'd0;
            fva_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_PASS) begin
                addr_q <= req_pa;
                wr_q   <= req_write;
                sz_q   <= req_size;
            end
            if (state_d == ST_TRAP) begin
                fva_q <= req_va;
            end
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        rsp_valid   = 1'b0;
        fault_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PASS: rsp_valid   = 1'b1;
            ST_TRAP: fault_pulse = 1'b1;
            default: ;
        endcase
    end

    assign rsp_addr   = addr_q;
    assign rsp_write  = wr_q;
    assign rsp_size   = sz_q;
    assign fault_addr = fva_q;

endmodule

// File: rtl/task_reloc_unit.sv
module task_reloc_unit #(
    parameter int unsigned ADDR_W    = reloc_pkg::ADDR_W,
    parameter int unsigned NUM_TASKS = reloc_pkg::NUM_TASKS,
    localparam int unsigned TASK_W   = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_priv,
    input  logic              cfg_field,
    input  logic [TASK_W-1:0] cfg_task,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic [TASK_W-1:0] cur_task,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_write,
    output logic [1:0]        rsp_size,
    output logic              fault_pulse,
    output logic [ADDR_W-1:0] fault_addr
);

    logic [ADDR_W-1:0] sel_base, sel_limit, phys;
    logic              fits;

    reloc_regfile #(.AW(ADDR_W), .NT(NUM_TASKS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_priv  (cfg_priv),
        .wr_field (cfg_field),
        .wr_task  (cfg_task),
        .wr_data  (cfg_data),
        .rd_task  (cur_task),
        .rd_base  (sel_base),
        .rd_limit (sel_limit)
    );

    reloc_xlate #(.AW(ADDR_W)) u_xlate (
        .va        (req_addr),
        .size      (req_size),
        .base      (sel_base),
        .limit     (sel_limit),
        .pa        (phys),
        .in_bounds (fits)
    );

    reloc_fsm #(.AW(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ok      (fits),
        .req_va      (req_addr),
        .req_pa      (phys),
        .req_write   (req_write),
        .req_size    (req_size),
        .rsp_valid   (rsp_valid),
        .rsp_addr    (rsp_addr),
        .rsp_write   (rsp_write),
        .rsp_size    (rsp_size),
        .fault_pulse (fault_pulse),
        .fault_addr  (fault_addr)
    );

endmodule

// File: rtl/reloc_chk.sv
module reloc_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          req_write,
    input logic [1:0]    req_size,
    input logic          rsp_valid,
    input logic          rsp_write,
    input logic [1:0]    rsp_size,
    input logic          fault_pulse,
    input logic [AW-1:0] fault_addr
);

    // R9
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && fault_pulse));

    // R9
    valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R6
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> $past(req_valid));

    // R2
    echo_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_write == $past(req_write)) && (rsp_size == $past(req_size)));

    // R6
    fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> fault_addr == $past(req_addr));

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_pulse |-> $stable(fault_addr));

    // R4
    rsvd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd3) |=> fault_pulse);

endmodule

bind task_reloc_unit reloc_chk #(.AW(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .req_size    (req_size),
    .rsp_valid   (rsp_valid),
    .rsp_write   (rsp_write),
    .rsp_size    (rsp_size),
    .fault_pulse (fault_pulse),
    .fault_addr  (fault_addr)
);

// File: tb/task_reloc_unit_test.sv
`timescale 1ns/1ps
module task_reloc_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_priv = 1'b0, cfg_field = 1'b0;
    logic [2:0]  cfg_task = '0;
    logic [31:0] cfg_data = '0;
    logic [2:0]  cur_task = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        rsp_valid, rsp_write, fault_pulse;
    logic [31:0] rsp_addr, fault_addr;
    logic [1:0]  rsp_size;

    always #2 clk = ~clk;

    task_reloc_unit uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_field(cfg_field),
        .cfg_task(cfg_task), .cfg_data(cfg_data), .cur_task(cur_task),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_size(req_size), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_write(rsp_write), .rsp_size(rsp_size),
        .fault_pulse(fault_pulse), .fault_addr(fault_addr)
    );

    // Reference model state
    logic [31:0] m_base [8];
    logic [31:0] m_lim  [8];
    logic        e_valid, e_fault, e_write, live;
    logic [31:0] e_addr, e_faddr;
    logic [1:0]  e_size;
    string       tag = "R1";
    int          vectors = 0, miscompares = 0;
    bit          done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 8; t++) begin m_base[t] = '0; m_lim[t] = '0; end
            e_valid = 0; e_fault = 0; e_write = 0; e_addr = '0; e_faddr = '0; e_size = '0;
            live = 1;
        end else begin
            longint unsigned nb, endx;
            bit ok;
            e_valid = 0; e_fault = 0;
            if (req_valid) begin
                case (req_size)
                    2'd0: nb = 1;
                    2'd1: nb = 2;
                    2'd2: nb = 4;
                    default: nb = 0;
                endcase
                endx = longint'(req_addr) + nb;
                ok = (req_size != 2'd3) && (endx <= longint'(m_lim[cur_task]));
                if (ok) begin
                    e_valid = 1;
                    e_addr  = req_addr + m_base[cur_task];
                    e_write = req_write;
                    e_size  = req_size;
                end else begin
                    e_fault = 1;
                    e_faddr = req_addr;
                end
            end
            if (cfg_we && cfg_priv) begin
                if (cfg_field) m_lim[cfg_task] = cfg_data;
                else           m_base[cfg_task] = cfg_data;
            end
        end
    end

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live && !done) begin
            cmp("rsp_valid", 32'(rsp_valid), 32'(e_valid));
            cmp("fault_pulse", 32'(fault_pulse), 32'(e_fault));
            cmp("fault_addr", fault_addr, e_faddr);
            if (e_valid) begin
                cmp("rsp_addr", rsp_addr, e_addr);
                cmp("rsp_write", 32'(rsp_write), 32'(e_write));
                cmp("rsp_size", 32'(rsp_size), 32'(e_size));
            end
        end
    end

    task automatic step(input bit we, input bit pr, input bit fld, input int ct,
                        input logic [31:0] cd, input bit rv, input int tid,
                        input logic [31:0] va, input logic [1:0] sz, input bit wr);
        @(negedge clk);
        cfg_we = we; cfg_priv = pr; cfg_field = fld; cfg_task = ct[2:0]; cfg_data = cd;
        req_valid = rv; cur_task = tid[2:0]; req_addr = va; req_size = sz; req_write = wr;
    endtask

    task automatic cfg(input bit pr, input bit fld, input int t, input logic [31:0] d);
        step(1, pr, fld, t, d, 0, 0, 0, 0, 0);
    endtask

    task automatic req(input int t, input logic [31:0] va, input logic [1:0] sz, input bit wr);
        step(0, 0, 0, 0, 0, 1, t, va, sz, wr);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic report();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        rst_n = 1'b1;
        idle(); idle();
        req(0, 32'h0, 2'd0, 0);            // unprogrammed: fault
        req(5, 32'h40, 2'd2, 1);
        idle();

        tag = "R7";
        cfg(0, 1, 0, 32'h1000);            // unprivileged size write dropped
        cfg(0, 0, 0, 32'h5000_0000);
        req(0, 32'h0, 2'd0, 0);            // still faults
        idle();

        tag = "R2";
        cfg(1, 0, 0, 32'h1000_0000); cfg(1, 1, 0, 32'h1000);
        cfg(1, 0, 1, 32'h1100_0000); cfg(1, 1, 1, 32'h1000);
        cfg(1, 0, 2, 32'h1200_0000); cfg(1, 1, 2, 32'h100);
        req(0, 32'h0, 2'd2, 0);
        req(0, 32'h124, 2'd1, 1);
        tag = "R3";
        req(1, 32'h0, 2'd2, 1);
        req(2, 32'h0, 2'd0, 0);
        req(2, 32'h80, 2'd2, 1);
        req(1, 32'h100, 2'd2, 0);          // in task 1's space
        req(2, 32'h100, 2'd2, 0);          // beyond task 2's space
        idle();

        tag = "R5";
        req(0, 32'hFFC, 2'd2, 0);          // last word fits
        req(0, 32'hFFD, 2'd2, 0);          // crosses by one byte
        req(0, 32'hFFE, 2'd1, 1);
        req(0, 32'hFFF, 2'd1, 1);          // half crosses
        req(0, 32'hFFF, 2'd0, 0);
        req(0, 32'h1000, 2'd0, 0);
        cfg(1, 0, 3, 32'hF000_0000); cfg(1, 1, 3, 32'hFFFF_FFFF);
        tag = "R2";
        req(3, 32'h2000_0000, 2'd2, 0);    // wraps to 0x10000000
        tag = "R5";
        req(3, 32'hFFFF_FFFE, 2'd2, 0);    // runs past the top: fault
        req(3, 32'hFFFF_FFFE, 2'd0, 1);    // byte fits

        tag = "R4";
        req(0, 32'h10, 2'd3, 0);
        req(3, 32'h0, 2'd3, 1);
        idle();

        tag = "R6";
        req(2, 32'h200, 2'd0, 0);
        req(2, 32'h300, 2'd0, 0);          // back-to-back faults
        idle(); idle();
        req(2, 32'h10, 2'd0, 0);           // pass leaves sticky value
        idle();

        tag = "R8";
        step(1, 1, 0, 0, 32'h2000_0000, 1, 0, 32'h4, 2'd2, 0);  // old base
        req(0, 32'h4, 2'd2, 0);                                   // new base
        step(1, 1, 1, 0, 32'h0, 1, 0, 32'h8, 2'd0, 0);           // old size
        req(0, 32'h8, 2'd0, 0);                                   // now faults
        tag = "R7";
        cfg(1, 1, 0, 32'h40);
        cfg(0, 1, 0, 32'h0);               // unprivileged shrink dropped
        req(0, 32'h3C, 2'd2, 0);
        cfg(0, 0, 0, 32'h0);
        req(0, 32'h3C, 2'd2, 1);

        tag = "R9";
        idle(); idle(); idle();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule